// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is one timer channel. A 32-bit counter counts down once per prescaled tick. When a tick arrives with the counter already at zero, the counter loads a reload constant and raises an underflow flag. An interrupt line is high whenever that flag and its enable bit are both set.

Software reaches four word registers through a synchronous register bus: the reload constant, the live counter, a control word and a capture register. An external `run` input starts and stops the channel. A small state machine registers `run` and has two states:

- `CH_HALTED`: the prescaler and the counter hold their values.
- `CH_RUNNING`: the prescaler advances.

There are two transitions. `GO` goes from `CH_HALTED` to `CH_RUNNING` when `run` is sampled high. `PAUSE` goes from `CH_RUNNING` to `CH_HALTED` when `run` is sampled low.

Software may select the edge-select, capture-mode and external-clock options. They are stored but have no effect on counting.

Top module: `countdown_channel`

## Requirements
- R1: After reset, the reload register and the counter read 0xFFFFFFFF, the control and capture registers read 0, and `irq` is 0.
- R2: The word index is `bus_addr[3:2]`: 0 selects reload, 1 the counter, 2 control and 3 capture. `bus_addr[1:0]` is ignored. `bus_rdata` shows the selected register in the same cycle while `bus_en`=1 and `bus_wr`=0, and is 0 otherwise. A write happens at the clock edge where `bus_en`=1 and `bus_wr`=1.
- R3: The state becomes `CH_RUNNING` on the edge after `run` is sampled 1, and `CH_HALTED` on the edge after it is sampled 0. In `CH_HALTED` the prescaler and the counter hold their values.
- R4: Control bits [2:0] pick the tick divisor: codes 0 to 4 give 4, 16, 64, 256 and 1024 running cycles per tick. Codes 5, 6 and 7 give no ticks.
- R5: A tick with a nonzero counter decrements it by one.
- R6: A tick with the counter at 0 loads the reload value and sets the underflow flag, which is control bit 8.
- R7: A counter write takes effect at that edge. It overrides a tick in the same cycle and suppresses that cycle's underflow.
- R8: A control write with bit 8 = 0 clears the flag. A write with bit 8 = 1 leaves the flag as it is. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high exactly when the flag and control bit 5 are both 1.
- R10: Control reads return the stored bits [7:0], bit 8 as the flag, and 0 in bits [31:9]. Bits [4:3] and [7:6] are stored without effect, and written bits [31:9] are dropped.
- R11: A control write that changes bits [2:0] restarts the prescaler phase. A control write that keeps the same code does not disturb the phase.
- R12: Writing the reload register leaves the running count alone; the new value is used at the next underflow. The capture register is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) / stop (0) request |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] are the word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench builds the block with its default 32-bit data width and five divisor codes. It loads reload and counter values of a few units, so that underflows at divisor 4 come every handful of cycles. This keeps even the 1024 divisor within a few thousand cycles. A behavioural model follows the phase, counter, flag and control state. While idle, the bench reads the counter on every clock and compares it with the model. This exposes single-cycle slips in the run latency, the prescaler restart and the priority of writes over ticks.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic {
        CH_HALTED  = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    localparam int ADDR_W    = 4;
    localparam int CODE_W    = 3;
    localparam int CTRL_W    = 8;
    localparam int UIE_BIT   = 5;
    localparam int UF_BIT    = 8;
    localparam int STEP_LOG  = 2;
    localparam int NUM_DIV   = 5;

    localparam logic [1:0] W_RELOAD  = 2'd0;
    localparam logic [1:0] W_COUNT   = 2'd1;
    localparam logic [1:0] W_CONTROL = 2'd2;
    localparam logic [1:0] W_CAPTURE = 2'd3;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              uf_flag,
    output logic [DATA_W-1:0] reload,
    output logic [CTRL_W-1:0] ctrl,
    output logic              wr_cnt,
    output logic              flag_clr,
    output logic              code_change,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [1:0]        word_idx;
    logic              wr_any;
    logic              wr_rel;
    logic              wr_ctl;
    logic              wr_cap;
    logic [DATA_W-1:0] capture;
    logic              unused_bits;

    assign word_idx    = bus_addr[3:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:UF_BIT+1]};
    assign wr_any      = bus_en && bus_wr;
    assign wr_rel      = wr_any && (word_idx == W_RELOAD);
    assign wr_cnt      = wr_any && (word_idx == W_COUNT);
    assign wr_ctl      = wr_any && (word_idx == W_CONTROL);
    assign wr_cap      = wr_any && (word_idx == W_CAPTURE);
    assign flag_clr    = wr_ctl && !bus_wdata[UF_BIT];
    assign code_change = wr_ctl && (bus_wdata[CODE_W-1:0] != ctrl[CODE_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload  <= '1;
            ctrl    <= '0;
            capture <= '0;
        end else begin
            if (wr_rel) reload  <= bus_wdata;
            if (wr_ctl) ctrl    <= bus_wdata[CTRL_W-1:0];
            if (wr_cap) capture <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr) begin
            unique case (word_idx)
                W_RELOAD:  bus_rdata = reload;
                W_COUNT:   bus_rdata = cnt_val;
                W_CONTROL: begin
                    bus_rdata[CTRL_W-1:0] = ctrl;
                    bus_rdata[UF_BIT]     = uf_flag;
                end
                W_CAPTURE: bus_rdata = capture;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PW = STEP_LOG * NUM_DIV;

    logic [PW-1:0] term [NUM_DIV];
    logic [PW-1:0] pcnt;
    logic [PW-1:0] term_sel;
    logic          code_ok;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
        assign term[g] = PW'((64'd1 << (STEP_LOG * (g + 1))) - 64'd1);
    end

    always_comb begin
        term_sel = '0;
        code_ok  = 1'b0;
        for (int k = 0; k < NUM_DIV; k++) begin
            if (code == CODE_W'(k)) begin
                term_sel = term[k];
                code_ok  = 1'b1;
            end
        end
    end

    assign tick = running && code_ok && (pcnt == term_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (running && code_ok) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reload,
    input  logic              flag_clr,
    output logic              running,
    output logic [DATA_W-1:0] cnt,
    output logic              flag
);
    ch_state_e state_q, state_d;
    logic      underflow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALTED:  if (run)  state_d = CH_RUNNING;
            CH_RUNNING: if (!run) state_d = CH_HALTED;
            default:    state_d = CH_HALTED;
        endcase
    end

    always_comb begin
        running = (state_q == CH_RUNNING);
    end

    assign underflow = tick && (cnt == '0) && !wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '1;
            flag <= 1'b0;
        end else begin
            if (wr_cnt)         cnt <= wdata;
            else if (underflow) cnt <= reload;
            else if (tick)      cnt <= cnt - 1'b1;
            if (underflow)      flag <= 1'b1;
            else if (flag_clr)  flag <= 1'b0;
        end
    end
endmodule

// File: rtl/countdown_channel.sv
module countdown_channel
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] cnt;
    logic [CTRL_W-1:0] ctrl;
    logic              wr_cnt;
    logic              flag_clr;
    logic              code_change;
    logic              running;
    logic              tick;
    logic              flag;

    cdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt),
        .uf_flag(flag), .reload(reload), .ctrl(ctrl), .wr_cnt(wr_cnt),
        .flag_clr(flag_clr), .code_change(code_change), .bus_rdata(bus_rdata)
    );

    cdt_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .running(running), .clr(code_change),
        .code(ctrl[CODE_W-1:0]), .tick(tick)
    );

    cdt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wr_cnt(wr_cnt),
        .wdata(bus_wdata), .reload(reload), .flag_clr(flag_clr),
        .running(running), .cnt(cnt), .flag(flag)
    );

    assign irq = flag && ctrl[UIE_BIT];
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              running,
    input logic              wr_cnt,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload,
    input logic              flag,
    input logic              irq
);
    assert_halt_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);
    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_cnt) |=> $stable(cnt));
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && !wr_cnt) |=> cnt == $past(cnt) - 1'b1);
    assert_reload_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !wr_cnt) |=> (cnt == $past(reload)) && flag);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wdata));
    assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick && !wr_cnt));
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> !irq);
endmodule

bind countdown_channel cdt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
    .wr_cnt(wr_cnt), .wdata(bus_wdata), .cnt(cnt), .reload(reload),
    .flag(flag), .irq(irq)
);

// File: tb/test_countdown_channel.sv
module test_countdown_channel;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    countdown_channel #(.DATA_W(DW)) i_countdown_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic          m_run_q;
    int            m_phase;
    logic [DW-1:0] m_cnt, m_rel, m_cap;
    logic [7:0]    m_ctl;
    logic          m_flag;

    function automatic int divisor(input logic [2:0] c);
        return (c <= 3'd4) ? (4 << (2 * c)) : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run_q <= 0; m_phase <= 0; m_cnt <= '1; m_rel <= '1;
            m_cap <= '0; m_ctl <= '0; m_flag <= 0;
        end else begin
            automatic bit wr = bus_en && bus_wr;
            automatic int idx = bus_addr[3:2];
            automatic int dv = divisor(m_ctl[2:0]);
            automatic bit tk = m_run_q && dv != 0 && m_phase == dv - 1;
            automatic bit cw = wr && idx == 1;
            automatic bit uf = tk && m_cnt == 0 && !cw;
            if (wr && idx == 2 && bus_wdata[2:0] != m_ctl[2:0]) m_phase <= 0;
            else if (m_run_q && dv != 0) m_phase <= tk ? 0 : m_phase + 1;
            if (cw) m_cnt <= bus_wdata;
            else if (tk) m_cnt <= (m_cnt == 0) ? m_rel : m_cnt - 1;
            if (wr && idx == 0) m_rel <= bus_wdata;
            if (wr && idx == 2) m_ctl <= bus_wdata[7:0];
            if (wr && idx == 3) m_cap <= bus_wdata;
            if (uf) m_flag <= 1;
            else if (wr && idx == 2 && !bus_wdata[8]) m_flag <= 0;
            m_run_q <= run;
        end
    end

    function automatic logic [DW-1:0] exp_read(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_rel;
            2'd1: return m_cnt;
            2'd2: return {23'd0, m_flag, m_ctl};
            default: return m_cap;
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input bit wr, input logic [3:0] a, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        bus_en = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        if (!wr) check(tag, bus_rdata, exp_read(a));
        check("R9 irq", {31'd0, irq}, {31'd0, m_flag & m_ctl[5]});
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) op(0, 4'h4, '0, tag);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk); rst_n = 1;
        // R1 reset values
        op(0, 4'h0, '0, "R1 reload");
        op(0, 4'h4, '0, "R1 counter");
        op(0, 4'h8, '0, "R1 control");
        op(0, 4'hC, '0, "R1 capture");
        @(negedge clk); bus_en = 0; #1;
        check("R2 idle rdata", bus_rdata, '0);
        // R5 R6 R9: fast divisor, interrupt enabled
        op(1, 4'h0, 32'd3, "R12 reload");
        op(1, 4'h4, 32'd2, "R7 counter");
        op(1, 4'h8, 32'h120, "R8 ctl");
        op(0, 4'h8, '0, "R10 ctl read");
        run = 1;
        idle(60, "R5 R6 count");
        // R8 clearing and non-setting writes
        op(1, 4'h8, 32'h020, "R8 clr");
        op(0, 4'h8, '0, "R8 after clear");
        op(1, 4'h8, 32'h120, "R8 set-attempt");
        op(0, 4'h8, '0, "R8 one no set");
        // R9 enable off
        op(1, 4'h8, 32'h000, "R9 ie off");
        idle(40, "R9 flag no irq");
        op(0, 4'h8, '0, "R9 flag visible");
        // R7 counter writes every cycle
        for (int i = 0; i < 12; i++) op(1, 4'h5, 32'd7, "R7 write wins");
        idle(3, "R7 after");
        // R11 code change and same-code write
        op(1, 4'h8, 32'h001, "R11 code1");
        idle(10, "R11 phase");
        op(1, 4'h8, 32'h121, "R11 same code");
        idle(40, "R11 phase kept");
        // R4 larger divisors
        op(1, 4'h0, 32'd1, "R12 reload1");
        for (int c = 2; c <= 4; c++) begin
            op(1, 4'h8, 32'h100 | c, "R4 code");
            op(1, 4'h4, 32'd1, "R4 cnt");
            idle(3 * (4 << (2 * c)) + 5, "R4 divisor");
        end
        // R4 reserved codes
        op(1, 4'h8, 32'h005, "R4 code5");
        idle(80, "R4 code5 frozen");
        op(1, 4'h8, 32'h007, "R4 code7");
        idle(40, "R4 code7 frozen");
        // R3 halt and restart
        op(1, 4'h8, 32'h020, "R3 code0");
        idle(9, "R3 running");
        run = 0;
        idle(30, "R3 halted");
        run = 1;
        idle(20, "R3 resumed");
        // R10 reserved bits
        op(1, 4'h8, 32'hFFFF_FED8, "R10 write");
        op(0, 4'h8, '0, "R10 readback");
        // R12 reload change mid-count, capture storage, R2 byte lanes
        op(1, 4'h4, 32'd5, "R12 cnt");
        op(1, 4'h1, 32'd9, "R12 reload");
        idle(50, "R12 new reload");
        op(1, 4'hE, 32'hA5A5_0F0F, "R12 capture");
        op(0, 4'hD, '0, "R2 capture alias");
        op(0, 4'h3, '0, "R2 reload alias");
        op(0, 4'h0, '0, "R12 reload");
        @(negedge clk); bus_en = 0;
        summary();
    end
endmodule